// File: doc/BRIEF.md
# MDIO Management Master with Command Registers

This block lets software reach external PHY devices over a two-wire management bus. Software first loads a target register (port address, device field and register number). It then writes a command/data register with the busy bit set. The block serialises one management transaction on the MDC/MDIO pins and clears busy when the transaction ends. For a read, it returns the captured 16-bit value in the data field of the command register, and it posts a completion status that can raise an interrupt.

A per-port mode register selects the framing for each port. A port whose bit is set uses a single short-format frame with a 5-bit register number. Any other port uses the extended format: an address frame that carries a 16-bit register number, then a separate data frame. The MDC rate comes from a divider whose ratio software picks in the command register.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset every register reads 0, and MDC, the data-line enable and the interrupt output are low.
- R2: Register offsets are 0x200 for target, 0x204 for command, 0x214 for status, 0x218 for enable and 0x220 for port mode. The target register holds the register number in 15:0, the device field in 20:16 and the port in 25:21. The command register holds data in 15:0, the opcode in 17:16, a single-address flag in 18, the rate code in 21:19 and busy in 22. A write to the command register with bit 22 set starts a transaction, and busy reads 1 until the transaction ends.
- R3: While busy is 1, writes to the target and command registers leave their contents unchanged, and a command write with bit 22 set does not start a second transaction.
- R4: When the port (0 to 3) has its bit set in the mode register, the block sends one frame: 32 ones, start 01, opcode 01 for a write or 10 for a read, 5-bit port, the low 5 bits of the register number, turnaround 10, then 16 data bits, most significant bit first.
- R5: A port whose mode bit is clear, and every port 4 or above, uses two frames. Each frame starts with 32 ones. The first frame has start 00, opcode 00, port, device field, 16-bit register number. The second frame has start 00, opcode 01 (write) or 11 (read), port, device field, data.
- R6: Opcode code 3 is a read and code 1 is a write. During a read the block releases the data line for both turnaround bits and the 16 data bits. The sampled value then appears in bits 15:0 of the command register.
- R7: MDC idles low. Its period is 4 + 2*code system clocks for rate code 0 to 7. Data changes on the falling edge and is sampled on the rising edge.
- R8: In the cycle busy clears, status bit 12 becomes 1. That bit holds until software writes a 1 to bit 12 of the status register. Writing 0 there has no effect.
- R9: The interrupt output is status bit 12 AND enable bit 12. Bit 1 of the summary output follows status bit 12 whatever the enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the offset of the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |
| irq | output | 1 | Completion interrupt |
| mac_isr | output | 32 | Summary status, bit 1 = completion pending |

## Verification
A wrong sequencer position or frame register shows up within one frame as a wrong bit in the frame a PHY model decodes, since every frame is compared in full. A wrong rate code shows within two MDC edges as a wrong measured period. A wrong read-enable state shows within a turnaround as two drivers on the line, or as wrong returned data after the transaction. Busy, status and interrupt faults appear at the register port on the first poll after the last frame ends, and that poll also shows whether the protected registers took writes made while busy was high.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int CR_W       = 3;
  localparam int OP_LSB     = 16;
  localparam int SAD_BIT    = 18;
  localparam int CR_LSB     = 19;
  localparam int BUSY_BIT   = 22;
  localparam int DONE_BIT   = 12;
  localparam int SUM_BIT    = 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_FINAL} seq_state_e;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  pa;
    logic [4:0]  da;
    logic [15:0] data;
  } frame_t;

  function automatic logic [FRAME_BITS-1:0] pack_frame(frame_t f);
    return {32'hFFFF_FFFF, f.st, f.op, f.pa, f.da, 2'b10, f.data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [CR_W-1:0] cr,
  output logic            mdc,
  output logic            rise_stb,
  output logic            fall_stb
);
  localparam int CNT_W = CR_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  assign half_m1  = CNT_W'(cr) + CNT_W'(1);
  assign tick     = run && (cnt == half_m1);
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdc);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        launch,
  input  logic        use_c22,
  input  logic        is_read,
  input  logic [4:0]  port,
  input  logic [4:0]  mmd,
  input  logic [15:0] regnum,
  input  logic [15:0] wdata,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata,
  output logic        done
);
  seq_state_e            state;
  logic [FRAME_BITS-1:0] frame_q;
  logic [POS_W-1:0]      pos;
  logic [POS_W-1:0]      next_pos;
  logic                  rel_q;
  logic [FRAME_BITS-1:0] c22_f, adr_f, dat_f;

  assign active   = (state != SQ_IDLE);
  assign next_pos = pos + POS_W'(1);

  always_comb begin
    c22_f = pack_frame('{st: 2'b01, op: (is_read ? 2'b10 : 2'b01),
                         pa: port, da: regnum[4:0], data: wdata});
    adr_f = pack_frame('{st: 2'b00, op: 2'b00, pa: port, da: mmd, data: regnum});
    dat_f = pack_frame('{st: 2'b00, op: (is_read ? 2'b11 : 2'b01),
                         pa: port, da: mmd, data: wdata});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      frame_q <= '0;
      pos     <= '0;
      rel_q   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == SQ_IDLE) begin
        if (launch) begin
          state   <= use_c22 ? SQ_FINAL : SQ_LEAD;
          frame_q <= use_c22 ? c22_f : adr_f;
          rel_q   <= use_c22 && is_read;
          pos     <= '0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b1;
        end
      end else begin
        if (rise_stb && rel_q && pos >= POS_W'(DATA_POS))
          rdata <= {rdata[14:0], mdio_i};
        if (fall_stb) begin
          if (pos == POS_W'(FRAME_BITS - 1)) begin
            if (state == SQ_LEAD) begin
              state   <= SQ_FINAL;
              frame_q <= dat_f;
              rel_q   <= is_read;
              pos     <= '0;
              mdio_o  <= 1'b1;
              mdio_oe <= 1'b1;
            end else begin
              state   <= SQ_IDLE;
              mdio_o  <= 1'b0;
              mdio_oe <= 1'b0;
              done    <= 1'b1;
            end
          end else begin
            pos     <= next_pos;
            mdio_o  <= frame_q[~next_pos];
            mdio_oe <= !(rel_q && next_pos >= POS_W'(TA_POS));
          end
        end
      end
    end
  end

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state != SQ_IDLE && rel_q && pos >= POS_W'(TA_POS)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              PORTS    = 4,
  parameter logic [ADDR_W-1:0] OFF_SEL  = ADDR_W'('h200),
  parameter logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'('h204),
  parameter logic [ADDR_W-1:0] OFF_STAT = ADDR_W'('h214),
  parameter logic [ADDR_W-1:0] OFF_IEN  = ADDR_W'('h218),
  parameter logic [ADDR_W-1:0] OFF_MODE = ADDR_W'('h220)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              irq,
  output logic [31:0]       mac_isr
);
  logic [15:0]      regnum_q;
  logic [4:0]       mmd_q, port_q;
  logic [15:0]      data_q;
  logic [1:0]       op_q;
  logic             saddr_q;
  logic [CR_W-1:0]  cr_q;
  logic             busy_q, launch_q, st_q, ien_q;
  logic [PORTS-1:0] mode_q;
  logic [31:0]      rd_mux;
  logic             port_is_c22;

  logic        seq_active, seq_done, rise_stb, fall_stb;
  logic [15:0] seq_rdata;

  logic wr_sel, wr_cmd, wr_stat, wr_ien, wr_mode, start;
  assign wr_sel  = reg_wr && (reg_addr == OFF_SEL);
  assign wr_cmd  = reg_wr && (reg_addr == OFF_CMD);
  assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
  assign wr_ien  = reg_wr && (reg_addr == OFF_IEN);
  assign wr_mode = reg_wr && (reg_addr == OFF_MODE);
  assign start   = wr_cmd && !busy_q && reg_wdata[BUSY_BIT];

  always_comb begin
    port_is_c22 = 1'b0;
    for (int i = 0; i < PORTS; i++)
      if (port_q == 5'(i) && mode_q[i]) port_is_c22 = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == OFF_SEL) begin
      rd_mux[25:0] = {port_q, mmd_q, regnum_q};
    end else if (reg_addr == OFF_CMD) begin
      rd_mux[BUSY_BIT]          = busy_q;
      rd_mux[CR_LSB +: CR_W]    = cr_q;
      rd_mux[SAD_BIT]           = saddr_q;
      rd_mux[OP_LSB +: 2]       = op_q;
      rd_mux[15:0]              = data_q;
    end else if (reg_addr == OFF_STAT) begin
      rd_mux[DONE_BIT] = st_q;
    end else if (reg_addr == OFF_IEN) begin
      rd_mux[DONE_BIT] = ien_q;
    end else if (reg_addr == OFF_MODE) begin
      rd_mux[PORTS-1:0] = mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regnum_q  <= '0;
      mmd_q     <= '0;
      port_q    <= '0;
      data_q    <= '0;
      op_q      <= '0;
      saddr_q   <= 1'b0;
      cr_q      <= '0;
      busy_q    <= 1'b0;
      launch_q  <= 1'b0;
      st_q      <= 1'b0;
      ien_q     <= 1'b0;
      mode_q    <= '0;
      reg_rdata <= '0;
    end else begin
      launch_q <= start;
      if (wr_sel && !busy_q)
        {port_q, mmd_q, regnum_q} <= reg_wdata[25:0];
      if (wr_cmd && !busy_q) begin
        data_q  <= reg_wdata[15:0];
        op_q    <= reg_wdata[OP_LSB +: 2];
        saddr_q <= reg_wdata[SAD_BIT];
        cr_q    <= reg_wdata[CR_LSB +: CR_W];
      end else if (seq_done && op_q[1]) begin
        data_q <= seq_rdata;
      end
      if (start)         busy_q <= 1'b1;
      else if (seq_done) busy_q <= 1'b0;
      if (seq_done)                          st_q <= 1'b1;
      else if (wr_stat && reg_wdata[DONE_BIT]) st_q <= 1'b0;
      if (wr_ien)  ien_q  <= reg_wdata[DONE_BIT];
      if (wr_mode) mode_q <= reg_wdata[PORTS-1:0];
      reg_rdata <= rd_mux;
    end
  end

  assign irq = st_q && ien_q;
  always_comb begin
    mac_isr          = '0;
    mac_isr[SUM_BIT] = st_q;
  end

  mdio_clkgen u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (seq_active),
    .cr       (cr_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch_q),
    .use_c22  (port_is_c22),
    .is_read  (op_q[1]),
    .port     (port_q),
    .mmd      (mmd_q),
    .regnum   (regnum_q),
    .wdata    (data_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (seq_active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (seq_rdata),
    .done     (seq_done)
  );

  // R8
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> (st_q && !busy_q));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !seq_done) |=> busy_q);

  // R3
  target_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wr_sel) |=> $stable({port_q, mmd_q, regnum_q}));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(seq_done) || $past(wr_ien)));
endmodule

// File: tb/mdio_cmd_master_bench.sv
module mdio_cmd_master_bench;
  localparam logic [11:0] A_SEL = 12'h200, A_CMD = 12'h204, A_STAT = 12'h214,
                          A_IEN = 12'h218, A_MODE = 12'h220;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic [31:0] mac_isr;
  logic        phy_oe = 1'b0;
  logic        phy_v  = 1'b1;
  logic [15:0] phy_val;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_v : 1'b1);

  int checks = 0;
  int fails  = 0;
  int contention = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mdio_cmd_master u_mdio_cmd_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line),
    .irq(irq), .mac_isr(mac_isr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY-side monitor: decodes frames, answers reads, compares against queue
  logic        mdc_d = 1'b0;
  int          ones = 0;
  int          mpos = 0;
  bit          in_frame = 1'b0;
  bit          rd_flag = 1'b0;
  logic [31:0] w = '0;

  always @(negedge clk) begin
    if (mdio_oe && phy_oe) contention++;
    if (mdc && !mdc_d) begin
      if (!in_frame) begin
        if (mdio_line) begin
          if (ones < 64) ones++;
        end else begin
          if (ones >= 32) begin
            in_frame = 1'b1;
            w = '0;
            mpos = 1;
          end
          ones = 0;
        end
      end else begin
        w = {w[30:0], mdio_line};
        mpos++;
        if (mpos == 3) rd_flag = mdio_line;
        if (mpos == 32) begin
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R4 unexpected frame actual=%h expected=none", w);
          end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (w !== e) begin
              fails++;
              $display("FAIL %s frame actual=%h expected=%h", t, w, e);
            end
          end
          in_frame = 1'b0;
          rd_flag  = 1'b0;
          ones     = 0;
        end
      end
    end
    if (!mdc && mdc_d) begin
      if (in_frame && rd_flag && mpos >= 15 && mpos <= 31) begin
        phy_oe = 1'b1;
        phy_v  = (mpos == 15) ? 1'b0 : phy_val[31 - mpos];
      end else begin
        phy_oe = 1'b0;
        phy_v  = 1'b1;
      end
    end
    mdc_d = mdc;
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] fw(input logic [1:0] st, input logic [1:0] op,
                                     input logic [4:0] pa, input logic [4:0] da,
                                     input logic [15:0] d);
    return {st, op, pa, da, 2'b10, d};
  endfunction

  task automatic start_xfer(input logic [4:0] port, input logic [4:0] mmd,
                            input logic [15:0] regnum, input bit rd,
                            input logic [2:0] cr, input bit c22,
                            input logic [15:0] wd, input string tag);
    logic [15:0] dv;
    dv = rd ? phy_val : wd;
    if (c22) begin
      exp_q.push_back(fw(2'b01, rd ? 2'b10 : 2'b01, port, regnum[4:0], dv));
      tag_q.push_back(tag);
    end else begin
      exp_q.push_back(fw(2'b00, 2'b00, port, mmd, regnum));
      tag_q.push_back(tag);
      exp_q.push_back(fw(2'b00, rd ? 2'b11 : 2'b01, port, mmd, dv));
      tag_q.push_back(tag);
    end
    bus_wr(A_SEL, {6'b0, port, mmd, regnum});
    bus_wr(A_CMD, {9'b0, 1'b1, cr, 1'b0, (rd ? 2'b11 : 2'b01), wd});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(A_CMD, v);
      if (!v[22]) return;
    end
    check(1'b0, "R2 busy never cleared", v, 32'h0);
  endtask

  task automatic measure_period(input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    while (mdc)  @(negedge clk);
    while (!mdc) @(negedge clk);
    while (mdc)  begin @(negedge clk); n++; end
    while (!mdc) begin @(negedge clk); n++; end
    check(n == exp, tag, n, exp);
  endtask

  task automatic clear_status();
    bus_wr(A_STAT, 32'h0000_1000);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    report();
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; phy_val = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check({mdc, mdio_oe, irq} == 3'b000, "R1 pins after reset", {29'b0, mdc, mdio_oe, irq}, 0);
    bus_rd(A_SEL, v);  check(v == 0, "R1 target reg", v, 0);
    bus_rd(A_CMD, v);  check(v == 0, "R1 command reg", v, 0);
    bus_rd(A_STAT, v); check(v == 0, "R1 status reg", v, 0);
    bus_rd(A_MODE, v); check(v == 0, "R1 mode reg", v, 0);

    bus_wr(A_IEN, 32'h0000_1000);
    bus_wr(A_MODE, 32'h0000_0001);

    // short-format write to port 0 (R4), busy handling (R2, R3), rate (R7)
    start_xfer(5'd0, 5'd0, 16'h0005, 1'b0, 3'd0, 1'b1, 16'hA5A5, "R4");
    bus_rd(A_CMD, v);
    check(v == 32'h0041_A5A5, "R2 command readback while busy", v, 32'h0041_A5A5);
    bus_wr(A_SEL, 32'h03FF_FFFF);
    bus_wr(A_CMD, 32'h0070_1234);
    measure_period(4, "R7 period code 0");
    wait_idle();
    bus_rd(A_SEL, v);
    check(v == 32'h0000_0005, "R3 target unchanged", v, 32'h0000_0005);
    bus_rd(A_CMD, v);
    check(v == 32'h0001_A5A5, "R3 command unchanged, busy clear", v, 32'h0001_A5A5);
    bus_rd(A_STAT, v);
    check(v == 32'h0000_1000, "R8 status set on completion", v, 32'h0000_1000);
    check(irq == 1'b1, "R9 irq with enable set", {31'b0, irq}, 1);
    check(mac_isr == 32'h2, "R9 summary bit", mac_isr, 32'h2);
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, v);
    check(v == 32'h0000_1000, "R8 write 0 keeps status", v, 32'h0000_1000);
    clear_status();
    bus_rd(A_STAT, v);
    check(v == 32'h0, "R8 write 1 clears status", v, 32'h0);
    check(irq == 1'b0, "R9 irq after clear", {31'b0, irq}, 0);

    // short-format read (R6), code 2 period 8 (R7)
    phy_val = 16'h1234;
    start_xfer(5'd0, 5'd0, 16'h0002, 1'b1, 3'd2, 1'b1, 16'h0000, "R4");
    measure_period(8, "R7 period code 2");
    wait_idle();
    bus_rd(A_CMD, v);
    check(v[15:0] == 16'h1234, "R6 read data short format", {16'b0, v[15:0]}, 32'h1234);
    clear_status();

    // extended write, mode bit clear on port 1 (R5), code 1 period 6
    start_xfer(5'd1, 5'd3, 16'h0A0B, 1'b0, 3'd1, 1'b0, 16'h5555, "R5");
    measure_period(6, "R7 period code 1");
    wait_idle();
    clear_status();

    // all mode bits set; port 5 still extended; read (R5, R6); code 7 period 18
    bus_wr(A_MODE, 32'h0000_000F);
    phy_val = 16'hCAFE;
    start_xfer(5'd5, 5'd1, 16'hBEEF, 1'b1, 3'd7, 1'b0, 16'h0000, "R5");
    measure_period(18, "R7 period code 7");
    wait_idle();
    bus_rd(A_CMD, v);
    check(v[15:0] == 16'hCAFE, "R6 read data extended format", {16'b0, v[15:0]}, 32'hCAFE);
    clear_status();

    // enable cleared: status and summary set, irq stays low (R9)
    bus_wr(A_IEN, 32'h0);
    start_xfer(5'd3, 5'd0, 16'h001F, 1'b0, 3'd0, 1'b1, 16'hFFFF, "R4");
    wait_idle();
    bus_rd(A_STAT, v);
    check(v == 32'h0000_1000, "R8 status with enable clear", v, 32'h0000_1000);
    check(irq == 1'b0, "R9 irq masked", {31'b0, irq}, 0);
    check(mac_isr == 32'h2, "R9 summary unmasked", mac_isr, 32'h2);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected frames seen", exp_q.size(), 0);
    check(contention == 0, "R6 no line contention", contention, 0);
    report();
  end
endmodule